// File: doc/BRIEF.md
# Dual-Link Odd/Even Pixel Distributor

This block sits in front of two parallel display link lanes. It takes one pixel per clock at the full pixel rate and spreads the pixels over the two lanes in one of three ways, chosen by a mode input. In single mode only lane 0 is used: it passes each pixel straight through and lane 1 stays idle. In deep-colour mode a wide pixel is cut in two, with the low 24 bits on lane 0 and the upper colour bits on lane 1. In split mode the pixels alternate between the lanes by their position in the line. Split mode is the one to use when the pixel rate is higher than a single lane can carry.

In split mode, pixel 1 of every line is odd and goes to lane 0. The following even pixel goes to lane 1. The block waits until it has both pixels of a pair and then updates the two lanes in the same cycle, so each lane advances at half the input rate. A one-cycle strobe marks every lane update, and the lane side can use it as its half-rate clock enable. When a line ends on an odd pixel, the pair is sent with a blanked lane 1 word. Encoding, serialization and clock generation belong to later stages.

Top module: `dl_pixel_distributor`

## Requirements
- R1: While reset is held and in the first cycle after it is released, every output is zero, including `link_tick`.
- R2: When `mode_sel` is 2'b00 or 2'b11 (single mode), `link_tick` is 1 in every cycle. One cycle after each input, lane 0 shows the low `LANE_W` bits of the pixel together with its DE, hsync and vsync. Lane 1 shows a zero word with DE, hsync and vsync all at 0.
- R3: When `mode_sel` is 2'b10 (deep-colour mode), `link_tick` is 1 in every cycle. One cycle after each input, lane 0 carries `in_pix[LANE_W-1:0]` and lane 1 carries `in_pix[2*LANE_W-1:LANE_W]`, and both lanes carry the input DE and sync flags.
- R4: When `mode_sel` is 2'b01 (split mode), pixel positions are counted from 1. The count restarts when `in_line_start` is high with DE, or when DE rises. Odd positions go to lane 0 and even positions go to lane 1. Reading the lanes in order at each `link_tick` (lane 0 first) gives back the input pixel order.
- R5: In split mode, the cycle after an even-position pixel has `link_tick` high and both lane DEs high. Lane 1 holds that even pixel and lane 0 holds the odd pixel just before it.
- R6: In split mode, when a held odd pixel gets no partner, the cycle after the run ends has `link_tick` high, lane 0 DE high with the held pixel, and lane 1 DE low with a zero word. A run ends when DE falls or when a new line starts. This is one lane update per odd-length line.
- R7: On both lanes, in every mode, a lane word is zero whenever that lane's DE is 0.
- R8: In split mode, during blanking (DE low, nothing held), lane updates with DE 0 come on every second input cycle. The first one comes from the second blank cycle after the last lane update. Both lanes copy that cycle's hsync and vsync.
- R9: In split mode, a pair update and a flush update carry the hsync and vsync of the odd pixel on both lanes.
- R10: Lane 1 DE is never high while lane 0 DE is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | 00/11 single, 01 split by pixel position, 10 deep colour |
| in_pix | input | 2*LANE_W | Input pixel; upper half used only in deep-colour mode |
| in_de | input | 1 | Input pixel valid (display enable) |
| in_line_start | input | 1 | High with the first pixel of a line |
| in_hsync | input | 1 | Input horizontal sync |
| in_vsync | input | 1 | Input vertical sync |
| link_tick | output | 1 | One-cycle strobe marking a lane update |
| l0_pix | output | LANE_W | Lane 0 word |
| l0_de | output | 1 | Lane 0 DE |
| l0_hsync | output | 1 | Lane 0 hsync |
| l0_vsync | output | 1 | Lane 0 vsync |
| l1_pix | output | LANE_W | Lane 1 word |
| l1_de | output | 1 | Lane 1 DE |
| l1_hsync | output | 1 | Lane 1 hsync |
| l1_vsync | output | 1 | Lane 1 vsync |

## Verification
The split-mode state is a held-odd flag plus a blank-phase bit. If the flag is wrong, the next lane update is wrong: a pixel is lost, sent twice or sent on the wrong lane. The bench rebuilds the pixel order from the two lanes, so this shows up as a sequence mismatch no more than one pair later. If the blank-phase bit is wrong, the blanking update cadence is off within two cycles, and the totals of blank and flush updates over a sweep of line lengths and blank widths no longer match the closed-form counts. A wrong lane or mode decode shows up in the per-cycle comparison on the cycle after the input.

// File: rtl/dl_dist_pkg.sv
package dl_dist_pkg;

  typedef enum logic [1:0] {
    LM_SINGLE     = 2'b00,
    LM_SPLIT      = 2'b01,
    LM_DEEP       = 2'b10,
    LM_SINGLE_ALT = 2'b11
  } link_mode_e;

  typedef struct packed {
    logic hs;
    logic vs;
  } sync_t;

  function automatic logic mode_is_split(input logic [1:0] m);
    return m == LM_SPLIT;
  endfunction

  function automatic logic mode_is_deep(input logic [1:0] m);
    return m == LM_DEEP;
  endfunction

endpackage

// File: rtl/dl_phase_tracker.sv
module dl_phase_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic is_split,
  input  logic in_de,
  input  logic in_line_start,
  output logic take_odd,
  output logic emit_pair,
  output logic emit_flush,
  output logic emit_blank,
  output logic pend_o
);
  logic pend_q;
  logic blank_ph_q;

  always_comb begin
    take_odd   = is_split && in_de && (!pend_q || in_line_start);
    emit_pair  = is_split && pend_q && in_de && !in_line_start;
    emit_flush = is_split && pend_q && (!in_de || in_line_start);
    emit_blank = is_split && !in_de && !pend_q && blank_ph_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      blank_ph_q <= 1'b0;
    end else begin
      pend_q     <= take_odd;
      blank_ph_q <= (is_split && !in_de && !pend_q) ? !blank_ph_q : 1'b0;
    end
  end

  assign pend_o = pend_q;

  // R5: at most one kind of lane update per cycle
  a_r5_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({emit_pair, emit_flush, emit_blank}));

  // R8: blanking updates never come back to back
  a_r8_blank_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    emit_blank |=> !emit_blank);

endmodule

// File: rtl/dl_pair_hold.sv
module dl_pair_hold #(
  parameter int LANE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [LANE_W-1:0]   pix_i,
  input  dl_dist_pkg::sync_t  sync_i,
  output logic [LANE_W-1:0]   pix_o,
  output dl_dist_pkg::sync_t  sync_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_o  <= '0;
      sync_o <= '0;
    end else if (load) begin
      pix_o  <= pix_i;
      sync_o <= sync_i;
    end
  end
endmodule

// File: rtl/dl_lane_mux.sv
module dl_lane_mux #(
  parameter int LANE_W = 24,
  localparam int IN_W = 2 * LANE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                is_split,
  input  logic                is_deep,
  input  logic [IN_W-1:0]     in_pix,
  input  logic                in_de,
  input  dl_dist_pkg::sync_t  cur_sync,
  input  logic [LANE_W-1:0]   hold_pix,
  input  dl_dist_pkg::sync_t  hold_sync,
  input  logic                emit_pair,
  input  logic                emit_flush,
  input  logic                emit_blank,
  output logic                tick_o,
  output logic [LANE_W-1:0]   l0_pix_o,
  output logic                l0_de_o,
  output dl_dist_pkg::sync_t  l0_sync_o,
  output logic [LANE_W-1:0]   l1_pix_o,
  output logic                l1_de_o,
  output dl_dist_pkg::sync_t  l1_sync_o
);
  import dl_dist_pkg::*;

  function automatic logic [LANE_W-1:0] low_half(input logic [IN_W-1:0] p);
    return p[LANE_W-1:0];
  endfunction

  function automatic logic [LANE_W-1:0] high_half(input logic [IN_W-1:0] p);
    return p[IN_W-1:LANE_W];
  endfunction

  function automatic logic [LANE_W-1:0] gate_word(input logic [LANE_W-1:0] w,
                                                  input logic de);
    return de ? w : '0;
  endfunction

  logic              fire;
  logic [LANE_W-1:0] n0_pix, n1_pix;
  logic              n0_de, n1_de;
  sync_t             n0_sync, n1_sync;

  always_comb begin
    fire    = 1'b1;
    n0_pix  = gate_word(low_half(in_pix), in_de);
    n0_de   = in_de;
    n0_sync = cur_sync;
    n1_pix  = '0;
    n1_de   = 1'b0;
    n1_sync = '0;
    if (is_deep) begin
      n1_pix  = gate_word(high_half(in_pix), in_de);
      n1_de   = in_de;
      n1_sync = cur_sync;
    end else if (is_split) begin
      fire = emit_pair || emit_flush || emit_blank;
      if (emit_pair) begin
        n0_pix  = hold_pix;
        n0_de   = 1'b1;
        n0_sync = hold_sync;
        n1_pix  = low_half(in_pix);
        n1_de   = 1'b1;
        n1_sync = hold_sync;
      end else if (emit_flush) begin
        n0_pix  = hold_pix;
        n0_de   = 1'b1;
        n0_sync = hold_sync;
        n1_sync = hold_sync;
      end else begin
        n0_pix  = '0;
        n0_de   = 1'b0;
        n1_sync = cur_sync;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_o    <= 1'b0;
      l0_pix_o  <= '0;
      l0_de_o   <= 1'b0;
      l0_sync_o <= '0;
      l1_pix_o  <= '0;
      l1_de_o   <= 1'b0;
      l1_sync_o <= '0;
    end else begin
      tick_o <= fire;
      if (fire) begin
        l0_pix_o  <= n0_pix;
        l0_de_o   <= n0_de;
        l0_sync_o <= n0_sync;
        l1_pix_o  <= n1_pix;
        l1_de_o   <= n1_de;
        l1_sync_o <= n1_sync;
      end
    end
  end

  // R7: a lane with DE low carries a zero word
  a_r7_blank_words: assert property (@(posedge clk) disable iff (!rst_n)
    (!l0_de_o |-> l0_pix_o == '0) and (!l1_de_o |-> l1_pix_o == '0));

endmodule

// File: rtl/dl_pixel_distributor.sv
module dl_pixel_distributor #(
  parameter int LANE_W = 24,
  localparam int IN_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic [IN_W-1:0]   in_pix,
  input  logic              in_de,
  input  logic              in_line_start,
  input  logic              in_hsync,
  input  logic              in_vsync,
  output logic              link_tick,
  output logic [LANE_W-1:0] l0_pix,
  output logic              l0_de,
  output logic              l0_hsync,
  output logic              l0_vsync,
  output logic [LANE_W-1:0] l1_pix,
  output logic              l1_de,
  output logic              l1_hsync,
  output logic              l1_vsync
);
  import dl_dist_pkg::*;

  logic              is_split, is_deep;
  logic              take_odd, emit_pair, emit_flush, emit_blank, pend;
  logic [LANE_W-1:0] hold_pix;
  sync_t             hold_sync, cur_sync, l0_sync, l1_sync;

  assign is_split = mode_is_split(mode_sel);
  assign is_deep  = mode_is_deep(mode_sel);
  assign cur_sync = '{hs: in_hsync, vs: in_vsync};

  dl_phase_tracker phase_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .is_split      (is_split),
    .in_de         (in_de),
    .in_line_start (in_line_start),
    .take_odd      (take_odd),
    .emit_pair     (emit_pair),
    .emit_flush    (emit_flush),
    .emit_blank    (emit_blank),
    .pend_o        (pend)
  );

  dl_pair_hold #(.LANE_W(LANE_W)) hold_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (take_odd),
    .pix_i  (in_pix[LANE_W-1:0]),
    .sync_i (cur_sync),
    .pix_o  (hold_pix),
    .sync_o (hold_sync)
  );

  dl_lane_mux #(.LANE_W(LANE_W)) mux_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .is_split   (is_split),
    .is_deep    (is_deep),
    .in_pix     (in_pix),
    .in_de      (in_de),
    .cur_sync   (cur_sync),
    .hold_pix   (hold_pix),
    .hold_sync  (hold_sync),
    .emit_pair  (emit_pair),
    .emit_flush (emit_flush),
    .emit_blank (emit_blank),
    .tick_o     (link_tick),
    .l0_pix_o   (l0_pix),
    .l0_de_o    (l0_de),
    .l0_sync_o  (l0_sync),
    .l1_pix_o   (l1_pix),
    .l1_de_o    (l1_de),
    .l1_sync_o  (l1_sync)
  );

  assign l0_hsync = l0_sync.hs;
  assign l0_vsync = l0_sync.vs;
  assign l1_hsync = l1_sync.hs;
  assign l1_vsync = l1_sync.vs;

  // R10: lane 1 is only active alongside lane 0
  a_r10_l1_needs_l0: assert property (@(posedge clk) disable iff (!rst_n)
    l1_de |-> l0_de);

  // R2: single mode leaves lane 1 idle and updates every cycle
  a_r2_single_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_split && !is_deep) |=> (link_tick && !l1_de && l1_pix == '0));

  // R5: a completed pair drives both lanes in the next cycle
  a_r5_pair_update: assert property (@(posedge clk) disable iff (!rst_n)
    emit_pair |=> (link_tick && l0_de && l1_de));

  // R6: a held odd pixel at the end of a run goes out alone
  a_r6_flush_lone: assert property (@(posedge clk) disable iff (!rst_n)
    (is_split && pend && !in_de) |=> (link_tick && l0_de && !l1_de));

endmodule

// File: tb/dl_pixel_distributor_tb_top.sv
`timescale 1ns/1ps
module dl_pixel_distributor_tb_top;
  localparam int LW = 24;
  localparam int IW = 2 * LW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [1:0] mode_sel;
  logic [IW-1:0] in_pix;
  logic in_de, in_line_start, in_hsync, in_vsync;
  logic link_tick, l0_de, l0_hsync, l0_vsync, l1_de, l1_hsync, l1_vsync;
  logic [LW-1:0] l0_pix, l1_pix;

  dl_pixel_distributor #(.LANE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .in_pix(in_pix),
    .in_de(in_de), .in_line_start(in_line_start), .in_hsync(in_hsync),
    .in_vsync(in_vsync), .link_tick(link_tick), .l0_pix(l0_pix),
    .l0_de(l0_de), .l0_hsync(l0_hsync), .l0_vsync(l0_vsync),
    .l1_pix(l1_pix), .l1_de(l1_de), .l1_hsync(l1_hsync), .l1_vsync(l1_vsync)
  );

  int total = 0;
  int bad = 0;
  logic [1:0] p_mode = 2'b00;
  logic [IW-1:0] p_pix = '0;
  logic p_de = 0, p_hs = 0, p_vs = 0;
  int p_pos = 0;
  int cur_pos = 0;
  int n_exp = 0, n_rec = 0;
  logic [LW-1:0] exp_pix [0:1023];
  logic [LW-1:0] rec_pix [0:1023];
  bit exp_lane [0:1023];
  bit rec_lane [0:1023];
  int flush_cnt = 0, blank_cnt = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] mkpix(input int line, input int i);
    logic [LW-1:0] lo;
    lo = LW'(line * 131 + i * 7 + 3);
    return {~lo, lo};
  endfunction

  task automatic monitor();
    logic [LW-1:0] plo, phi;
    plo = p_de ? p_pix[LW-1:0] : '0;
    phi = p_de ? p_pix[IW-1:LW] : '0;
    if (p_mode == 2'b00 || p_mode == 2'b11) begin
      chk(link_tick && l0_pix == plo && l0_de == p_de && l0_hsync == p_hs &&
          l0_vsync == p_vs && !l1_de && l1_pix == '0 && !l1_hsync && !l1_vsync,
          "R2", "single lanes", {l0_pix, l0_de, l1_de, link_tick},
          {plo, p_de, 1'b0, 1'b1});
    end else if (p_mode == 2'b10) begin
      chk(link_tick && l0_pix == plo && l1_pix == phi && l0_de == p_de &&
          l1_de == p_de && l0_hsync == p_hs && l1_hsync == p_hs &&
          l0_vsync == p_vs && l1_vsync == p_vs,
          "R3", "deep lanes", {l1_pix, l0_pix}, {phi, plo});
    end else begin
      if (link_tick) begin
        chk(!(l1_de && !l0_de), "R10", "lane1 without lane0",
            {l1_de, l0_de}, {1'b0, l0_de});
        chk((l0_de || l0_pix == '0) && (l1_de || l1_pix == '0), "R7",
            "blank word", {l1_pix, l0_pix}, 0);
        if (l0_de) begin rec_pix[n_rec] = l0_pix; rec_lane[n_rec] = 0; n_rec++; end
        if (l1_de) begin rec_pix[n_rec] = l1_pix; rec_lane[n_rec] = 1; n_rec++; end
        if (l0_de && !l1_de) flush_cnt++;
        if (!l0_de) begin
          blank_cnt++;
          chk(l0_hsync == p_hs && l1_hsync == p_hs && l0_vsync == p_vs &&
              l1_vsync == p_vs, "R8", "blank sync",
              {l0_hsync, l1_hsync, l0_vsync, l1_vsync}, {p_hs, p_hs, p_vs, p_vs});
        end
      end
      if (p_de && (p_pos % 2 == 0)) begin
        chk(link_tick && l0_de && l1_de && l1_pix == p_pix[LW-1:0], "R5",
            "pair update", {link_tick, l0_de, l1_de, l1_pix},
            {3'b111, p_pix[LW-1:0]});
        chk(l0_hsync == p_hs && l1_hsync == p_hs && l0_vsync == p_vs &&
            l1_vsync == p_vs, "R9", "pair sync",
            {l0_hsync, l1_hsync, l0_vsync, l1_vsync}, {p_hs, p_hs, p_vs, p_vs});
      end
    end
  endtask

  task automatic step(input logic [1:0] m, input logic de, input logic ls,
                      input logic hs, input logic vs, input logic [IW-1:0] px);
    @(posedge clk);
    #1;
    p_mode = mode_sel; p_pix = in_pix; p_de = in_de;
    p_hs = in_hsync; p_vs = in_vsync; p_pos = cur_pos;
    if (de) cur_pos = (ls || !in_de) ? 1 : cur_pos + 1;
    else cur_pos = 0;
    if (de && m == 2'b01) begin
      exp_pix[n_exp] = px[LW-1:0];
      exp_lane[n_exp] = (cur_pos % 2 == 0);
      n_exp++;
    end
    mode_sel = m; in_de = de; in_line_start = ls;
    in_hsync = hs; in_vsync = vs; in_pix = de ? px : '0;
    @(negedge clk);
    monitor();
  endtask

  task automatic line(input logic [1:0] m, input int n, input int b,
                      input int idx, input bit ls_first);
    logic vs;
    vs = (idx % 4 == 0);
    for (int i = 0; i < n; i++) step(m, 1'b1, ls_first && i == 0, 1'b0, vs, mkpix(idx, i));
    for (int j = 0; j < b; j++) step(m, 1'b0, 1'b0, j < 2, vs, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog run did not finish act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    int eb, ef, b0, f0, li;
    rst_n = 0; mode_sel = 2'b00; in_pix = '0; in_de = 0;
    in_line_start = 0; in_hsync = 0; in_vsync = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!link_tick && l0_pix == '0 && l1_pix == '0 && !l0_de && !l1_de &&
        !l0_hsync && !l0_vsync && !l1_hsync && !l1_vsync, "R1", "reset outputs",
        {link_tick, l0_de, l1_de, l0_pix}, 0);

    // R2: single mode, both encodings
    for (int l = 0; l < 3; l++) line(2'b00, 6, 3, l, 1);
    line(2'b11, 5, 2, 3, 1);
    // R3: deep-colour mode
    for (int l = 0; l < 3; l++) line(2'b10, 7, 3, l + 4, 1);

    // R4 R6 R8: split sweep over line lengths and blank widths
    b0 = blank_cnt; f0 = flush_cnt; eb = 0; ef = 0; li = 10;
    for (int n = 1; n <= 9; n++) begin
      for (int b = 1; b <= 4; b++) begin
        line(2'b01, n, b, li, 1);
        li++;
        ef += n % 2;
        eb += (n % 2 == 1) ? (b - 1) / 2 : b / 2;
      end
    end
    line(2'b01, 3, 0, li, 1); li++;
    line(2'b01, 2, 2, li, 1); li++;
    ef += 1; eb += 1;
    line(2'b01, 5, 0, li, 1); li++;
    line(2'b01, 1, 3, li, 1); li++;
    ef += 2; eb += 1;
    line(2'b01, 3, 2, li, 0); li++;
    ef += 1;
    // drain in single mode so the last split update is observed
    line(2'b00, 3, 2, li, 1);

    chk(flush_cnt - f0 == ef, "R6", "lone-odd updates", flush_cnt - f0, ef);
    chk(blank_cnt - b0 == eb, "R8", "blank update count", blank_cnt - b0, eb);
    chk(n_rec == n_exp, "R4", "rebuilt pixel count", n_rec, n_exp);
    for (int i = 0; i < n_exp && i < n_rec; i++) begin
      chk(rec_pix[i] == exp_pix[i] && rec_lane[i] == exp_lane[i], "R4",
          "rebuilt order", {rec_lane[i], rec_pix[i]}, {exp_lane[i], exp_pix[i]});
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule